// File: doc/BRIEF.md
# Interrupt Pending-Active State Tracker

This block holds the per-source interrupt state for a small vectored interrupt controller. Each of `NUM_SRC` sources carries a pending flag and an active flag, which together give four states: inactive, pending, active, and active-and-pending. Each source can be set up either as level-sensitive or as pulse. A level source follows the present value of its line. A pulse source reacts only to a rising edge, which is found by comparing the line with a registered copy of itself.

Software-style strobes work per bit. They set or clear the pending flags and the enable flags, and they load the configuration vector that selects level or pulse for each source. The core takes a handler by presenting a source index with an entry strobe. A return strobe ends the handler of whichever source is active. A source records pending even while it is disabled. The enable flag only decides whether a pending source asks the core for service. The request goes out only while no source is active, and it names the lowest-numbered source that is both enabled and pending. All state is registered. The request and its index are decoded from that state without further delay.

Top module: `irq_state_tracker`

## Requirements
- R1: After reset every pending, active and enable flag is 0, every source is level-sensitive (configuration bit 0), and `req_o` is low.
- R2: A level source (configuration bit 0) becomes pending at a clock edge where its line is high and it is not active. While it is active, a high line does not set its pending flag.
- R3: A pulse source (configuration bit 1) becomes pending only on a rising edge of its line. A line held high after the edge does not set pending again.
- R4: A one on `set_pend_i[k]` makes source k pending. If `set_pend_i[k]` and `clr_pend_i[k]` are both high in the same cycle, the clear takes effect and the set does not.
- R5: An entry strobe with index k clears the pending flag of source k and sets its active flag. A pulse edge on that same cycle is kept as a new pending flag.
- R6: On a return strobe, an active level source becomes inactive. It is then pending if its line is high at that edge, and not pending if the line is low.
- R7: A rising edge on an active pulse source makes it active-and-pending. On return it becomes pending, not inactive.
- R8: Clear-pending on a level source whose line is high leaves its state unchanged. If the line is low, the pending flag is cleared.
- R9: Clear-pending on a pulse source moves pending to inactive, and moves active-and-pending to active.
- R10: A disabled source still records pending. `req_o` is high only when some source is both enabled and pending and no source is active.
- R11: While `req_o` is high, `req_idx_o` is the lowest index whose enable and pending flags are both 1.
- R12: `set_en_i[k]` sets enable k and `clr_en_i[k]` clears it. If both are high in the same cycle, the clear takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | NUM_SRC | Raw interrupt lines |
| cfg_we_i | input | 1 | Load the level/pulse configuration vector |
| cfg_pulse_i | input | NUM_SRC | Per-source kind: 1 = pulse, 0 = level |
| set_pend_i | input | NUM_SRC | Write-one-to-set pending |
| clr_pend_i | input | NUM_SRC | Write-one-to-clear pending |
| set_en_i | input | NUM_SRC | Write-one-to-set enable |
| clr_en_i | input | NUM_SRC | Write-one-to-clear enable |
| take_i | input | 1 | Handler entry strobe |
| take_idx_i | input | IDX_W | Index of the source being entered |
| ret_i | input | 1 | Handler return strobe |
| pend_o | output | NUM_SRC | Pending flags |
| act_o | output | NUM_SRC | Active flags |
| en_o | output | NUM_SRC | Enable flags |
| kind_o | output | NUM_SRC | Present level/pulse configuration |
| req_o | output | 1 | Service request to the core |
| req_idx_o | output | IDX_W | Lowest enabled pending source |

## Verification
The bench builds the block with `NUM_SRC` = 6. Six is not a power of two, so the 3-bit index has two codes that select no source. Random entry strobes with those codes must therefore leave every flag alone. Six sources still leave room for a mix of level and pulse sources. The configuration is reloaded at random, so kinds change while sources are pending or active. The directed part drives sources 0 (level), 1 (pulse) and 2 through each state transition, and covers the same-cycle collisions of set and clear.

// File: rtl/irq_state_pkg.sv
package irq_state_pkg;
   localparam int unsigned MAX_SRC = 64;

   typedef enum logic {
      KIND_LEVEL = 1'b0,
      KIND_PULSE = 1'b1
   } src_kind_e;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
   import irq_state_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic kind_i,
   input  logic sw_set_i,
   input  logic sw_clr_i,
   input  logic en_set_i,
   input  logic en_clr_i,
   input  logic enter_i,
   input  logic leave_i,
   output logic pend_o,
   output logic act_o,
   output logic en_o
);
   logic line_q, pend_q, act_q, en_q;
   logic rise, keep, hw, cand, pend_d, act_d;
   logic is_pulse;

   assign is_pulse = (src_kind_e'(kind_i) == KIND_PULSE);
   assign rise     = line_i & ~line_q;

   always_comb begin
      if (enter_i) begin
         act_d = 1'b1;
         keep  = 1'b0;
         hw    = is_pulse ? rise : 1'b0;
      end else if (leave_i && act_q) begin
         act_d = 1'b0;
         keep  = is_pulse ? pend_q : 1'b0;
         hw    = is_pulse ? rise : line_i;
      end else begin
         act_d = act_q;
         keep  = pend_q;
         hw    = is_pulse ? rise : (line_i & ~act_q);
      end
      cand = keep | hw;
      if (sw_clr_i)
         pend_d = (is_pulse || !line_i) ? 1'b0 : cand;
      else
         pend_d = cand | sw_set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         line_q <= line_i;
         pend_q <= pend_d;
         act_q  <= act_d;
         en_q   <= (en_q | en_set_i) & ~en_clr_i;
      end
   end

   assign pend_o = pend_q;
   assign act_o  = act_q;
   assign en_o   = en_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             any_o,
   output logic [IW-1:0]    idx_o
);
   always_comb begin
      idx_o = '0;
      for (int k = WIDTH - 1; k >= 0; k--) begin
         if (vec_i[k]) idx_o = IW'(k);
      end
   end
   assign any_o = |vec_i;
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
   import irq_state_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] line_i,
   input  logic               cfg_we_i,
   input  logic [NUM_SRC-1:0] cfg_pulse_i,
   input  logic [NUM_SRC-1:0] set_pend_i,
   input  logic [NUM_SRC-1:0] clr_pend_i,
   input  logic [NUM_SRC-1:0] set_en_i,
   input  logic [NUM_SRC-1:0] clr_en_i,
   input  logic               take_i,
   input  logic [IDX_W-1:0]   take_idx_i,
   input  logic               ret_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] act_o,
   output logic [NUM_SRC-1:0] en_o,
   output logic [NUM_SRC-1:0] kind_o,
   output logic               req_o,
   output logic [IDX_W-1:0]   req_idx_o
);
   if (NUM_SRC < 2 || NUM_SRC > MAX_SRC) begin : g_bad_count
      $error("irq_state_tracker: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] kind_q;
   logic [NUM_SRC-1:0] ready;
   logic               any_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        kind_q <= {NUM_SRC{KIND_LEVEL}};
      else if (cfg_we_i) kind_q <= cfg_pulse_i;
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      irq_src_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .line_i   (line_i[i]),
         .kind_i   (kind_q[i]),
         .sw_set_i (set_pend_i[i]),
         .sw_clr_i (clr_pend_i[i]),
         .en_set_i (set_en_i[i]),
         .en_clr_i (clr_en_i[i]),
         .enter_i  (take_i && (take_idx_i == IDX_W'(i))),
         .leave_i  (ret_i),
         .pend_o   (pend_o[i]),
         .act_o    (act_o[i]),
         .en_o     (en_o[i])
      );
   end

   assign ready = pend_o & en_o;

   irq_lowest_pick #(.WIDTH(NUM_SRC)) u_pick (
      .vec_i (ready),
      .any_o (any_ready),
      .idx_o (req_idx_o)
   );

   assign req_o  = any_ready && (act_o == '0);
   assign kind_o = kind_q;
endmodule

// File: rtl/irq_state_tracker_chk.sv
module irq_state_tracker_chk #(
   parameter int unsigned NUM_SRC = 8,
   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               take_i,
   input logic [IDX_W-1:0]   take_idx_i,
   input logic               ret_i,
   input logic [NUM_SRC-1:0] set_en_i,
   input logic [NUM_SRC-1:0] clr_en_i,
   input logic [NUM_SRC-1:0] pend_o,
   input logic [NUM_SRC-1:0] act_o,
   input logic [NUM_SRC-1:0] en_o,
   input logic               req_o,
   input logic [IDX_W-1:0]   req_idx_o
);
   logic [NUM_SRC-1:0] below_req;
   assign below_req = (NUM_SRC'(1) << req_idx_o) - NUM_SRC'(1);

   assert_take_sets_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && (take_idx_i < IDX_W'(NUM_SRC))) |=> act_o[$past(take_idx_i)]);

   assert_return_clears_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_i && !take_i) |=> ((act_o & $past(act_o)) == '0));

   assert_req_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> (act_o == '0 && pend_o[req_idx_o] && en_o[req_idx_o]));

   assert_req_lowest_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_o |-> ((pend_o & en_o & below_req) == '0));

   assert_enable_clear_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_en_i & clr_en_i) != '0) |=> ((en_o & $past(set_en_i & clr_en_i)) == '0));
endmodule

bind irq_state_tracker irq_state_tracker_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .take_i     (take_i),
   .take_idx_i (take_idx_i),
   .ret_i      (ret_i),
   .set_en_i   (set_en_i),
   .clr_en_i   (clr_en_i),
   .pend_o     (pend_o),
   .act_o      (act_o),
   .en_o       (en_o),
   .req_o      (req_o),
   .req_idx_o  (req_idx_o)
);

// File: tb/irq_state_tracker_test.sv
module irq_state_tracker_test;
   localparam int N  = 6;
   localparam int IW = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] line, cfg_pulse, set_pend, clr_pend, set_en, clr_en;
   logic cfg_we, take, ret;
   logic [IW-1:0] take_idx;
   logic [N-1:0] pend_o, act_o, en_o, kind_o;
   logic req_o;
   logic [IW-1:0] req_idx_o;

   logic [N-1:0] m_pend, m_act, m_en, m_kind, m_lineq;
   int nchk = 0;
   int nerr = 0;

   always #2 clk = ~clk;

   irq_state_tracker #(.NUM_SRC(N)) uut (
      .clk(clk), .rst_n(rst_n), .line_i(line), .cfg_we_i(cfg_we),
      .cfg_pulse_i(cfg_pulse), .set_pend_i(set_pend), .clr_pend_i(clr_pend),
      .set_en_i(set_en), .clr_en_i(clr_en), .take_i(take), .take_idx_i(take_idx),
      .ret_i(ret), .pend_o(pend_o), .act_o(act_o), .en_o(en_o), .kind_o(kind_o),
      .req_o(req_o), .req_idx_o(req_idx_o)
   );

   task automatic chk(string tag, logic [31:0] actual, logic [31:0] expected);
      nchk++;
      if (actual !== expected) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
      end
   endtask

   function automatic logic exp_req();
      return ((m_pend & m_en) != '0) && (m_act == '0);
   endfunction

   function automatic logic [IW-1:0] exp_idx();
      for (int k = 0; k < N; k++) if (m_pend[k] & m_en[k]) return IW'(k);
      return '0;
   endfunction

   // Reference update built from R2..R12
   task automatic model_edge();
      logic [N-1:0] np, na;
      for (int k = 0; k < N; k++) begin
         logic pulse, rise, keep, hw, cand;
         pulse = m_kind[k];
         rise  = line[k] & ~m_lineq[k];
         na[k] = m_act[k];
         if (take && take_idx == IW'(k)) begin
            na[k] = 1'b1; keep = 1'b0; hw = pulse & rise;
         end else if (ret && m_act[k]) begin
            na[k] = 1'b0; keep = pulse & m_pend[k]; hw = pulse ? rise : line[k];
         end else begin
            keep = m_pend[k]; hw = pulse ? rise : (line[k] & ~m_act[k]);
         end
         cand = keep | hw;
         if (clr_pend[k]) np[k] = (pulse || !line[k]) ? 1'b0 : cand;
         else             np[k] = cand | set_pend[k];
      end
      m_pend  = np;
      m_act   = na;
      m_en    = (m_en | set_en) & ~clr_en;
      m_lineq = line;
      if (cfg_we) m_kind = cfg_pulse;
   endtask

   task automatic clear_in();
      cfg_we = 0; cfg_pulse = '0; set_pend = '0; clr_pend = '0;
      set_en = '0; clr_en = '0; take = 0; take_idx = '0; ret = 0;
   endtask

   task automatic step(string tag);
      @(posedge clk);
      if (rst_n) model_edge();
      #1;
      chk({tag, " model pend"}, 32'(pend_o), 32'(m_pend));
      chk({tag, " model act"}, 32'(act_o), 32'(m_act));
      chk({tag, " model req"}, {31'd0, req_o}, {31'd0, exp_req()});
      if (exp_req()) chk({tag, " model idx"}, 32'(req_idx_o), 32'(exp_idx()));
      clear_in();
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      clear_in(); line = '0;
      m_pend = '0; m_act = '0; m_en = '0; m_kind = '0; m_lineq = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 pend", 32'(pend_o), 0);
      chk("R1 act", 32'(act_o), 0);
      chk("R1 en", 32'(en_o), 0);
      chk("R1 kind", 32'(kind_o), 0);
      chk("R1 req", {31'd0, req_o}, 0);

      cfg_we = 1; cfg_pulse = 6'b000010; step("R3 cfg");
      line[0] = 1; step("R2");
      chk("R2 level pends", {31'd0, pend_o[0]}, 1);
      chk("R10 disabled no req", {31'd0, req_o}, 0);
      set_en[0] = 1; step("R10");
      chk("R10 req", {31'd0, req_o}, 1);
      chk("R11 idx", 32'(req_idx_o), 0);
      take = 1; take_idx = 0; step("R5");
      chk("R5 act", 32'(act_o), 32'h1);
      chk("R5 pend cleared", {31'd0, pend_o[0]}, 0);
      chk("R10 no req while active", {31'd0, req_o}, 0);
      step("R2 hold");
      chk("R2 active blocks pend", {31'd0, pend_o[0]}, 0);
      ret = 1; step("R6");
      chk("R6 high line repends", {30'd0, act_o[0], pend_o[0]}, 32'b01);
      take = 1; take_idx = 0; step("R6 take");
      line[0] = 0; ret = 1; step("R6");
      chk("R6 low line inactive", {30'd0, act_o[0], pend_o[0]}, 0);

      line[1] = 1; step("R3");
      chk("R3 edge pends", {31'd0, pend_o[1]}, 1);
      line[1] = 1; clr_pend[1] = 1; step("R9");
      chk("R9 pulse clear", {31'd0, pend_o[1]}, 0);
      line[1] = 1; step("R3");
      chk("R3 held high no repend", {31'd0, pend_o[1]}, 0);
      line[1] = 0; step("R3");
      line[1] = 1; set_en[1] = 1; step("R3");
      chk("R11 idx pulse", 32'(req_idx_o), 1);
      take = 1; take_idx = 1; step("R5");
      chk("R5 pulse act", {30'd0, act_o[1], pend_o[1]}, 32'b10);
      line[1] = 0; step("R7");
      line[1] = 1; step("R7");
      chk("R7 active and pending", {30'd0, act_o[1], pend_o[1]}, 32'b11);
      line[1] = 1; clr_pend[1] = 1; step("R9");
      chk("R9 to active", {30'd0, act_o[1], pend_o[1]}, 32'b10);
      line[1] = 0; step("R7");
      line[1] = 1; step("R7");
      line[1] = 1; ret = 1; step("R7");
      chk("R7 return to pending", {30'd0, act_o[1], pend_o[1]}, 32'b01);

      line[0] = 1; line[1] = 0; step("R8");
      line[0] = 1; clr_pend[0] = 1; step("R8");
      chk("R8 high line unchanged", {31'd0, pend_o[0]}, 1);
      line[0] = 0; step("R8");
      line[0] = 0; clr_pend[0] = 1; step("R8");
      chk("R8 low line cleared", {31'd0, pend_o[0]}, 0);

      set_pend[2] = 1; clr_pend[2] = 1; step("R4");
      chk("R4 clear wins", {31'd0, pend_o[2]}, 0);
      set_pend[2] = 1; step("R4");
      chk("R4 set", {31'd0, pend_o[2]}, 1);
      set_en[2] = 1; line[0] = 1; step("R11");
      chk("R11 lowest", 32'(req_idx_o), 0);
      set_en[3] = 1; clr_en[3] = 1; clr_en[0] = 1; step("R12");
      chk("R12 en", 32'(en_o), 32'b000110);
      chk("R12 idx after clear", 32'(req_idx_o), 1);
      take = 1; take_idx = 3'd7; step("R5 bad idx");
      chk("R5 bad idx no act", 32'(act_o), 0);

      for (int n = 0; n < 4000; n++) begin
         line = N'($urandom) & N'($urandom);
         if ($urandom_range(0, 15) == 0) begin cfg_we = 1; cfg_pulse = N'($urandom); end
         if ($urandom_range(0, 3) == 0) set_pend = N'($urandom) & N'($urandom);
         if ($urandom_range(0, 3) == 0) clr_pend = N'($urandom) & N'($urandom);
         if ($urandom_range(0, 3) == 0) set_en = N'($urandom);
         if ($urandom_range(0, 5) == 0) clr_en = N'($urandom);
         if (req_o && $urandom_range(0, 1) == 0) begin take = 1; take_idx = req_idx_o; end
         else if ($urandom_range(0, 31) == 0) begin take = 1; take_idx = IW'($urandom); end
         if (act_o != '0 && $urandom_range(0, 3) == 0) ret = 1;
         step("R2/R3/R6/R7/R9 random");
      end
      finish_run();
   end
endmodule